// File: doc/BRIEF.md
# Clock Source Select Controller

This block holds the machine-clock selection state for a device that can run either from its main oscillator or from an on-chip PLL. One register carries a select bit, a 2-bit PLL multiplier code and a read-only busy flag. Writing 0 to the select bit while the main clock is in use requests the PLL. It starts a fixed stabilization wait of 2^WAIT_LOG2 main-clock cycles. It also sends a one-cycle clear pulse to an external timebase timer and its overflow flag. The clock-select output moves to the PLL only after that wait has run out.

The analog PLL and the glitch-free clock switch sit outside the block. They are driven by the select output, the multiplier output and a clock-enable output. That enable divides the main clock by MAIN_DIV while the main clock is selected. The block tells apart four synchronous reset sources: power-on, watchdog, external pin and software. Each one affects the stored state in its own way.

Top module: `clk_src_ctrl`

## Requirements
- R1: The register reads as {busy (bit 3), select (bit 2), multiplier (bits 1:0)}. Select 1 means main clock and 0 means PLL. Writes use bit 2 for select and bits 1:0 for the multiplier, and bit 3 is read-only.
- R2: Power-on reset sets select to 1, multiplier to 00 and busy to 0, and drives pll_sel_o and tb_clr_o low.
- R3: A write that changes select from 1 to 0 raises busy for exactly 2^WAIT_LOG2 main-clock cycles, starting the cycle after the write.
- R4: tb_clr_o is high for exactly one cycle, the cycle after a 1-to-0 select write is accepted. A write of 0 while select is already 0 gives no pulse and starts no wait.
- R5: pll_sel_o stays 0 while busy is 1, and becomes 1 on the cycle busy falls after a wait that completes.
- R6: Writing select = 1 during the wait ends it at once. busy drops, pll_sel_o stays 0 and no later switch to the PLL follows.
- R7: The multiplier field takes a written value only when select was 1 before the write. While select is 0, multiplier writes are ignored.
- R8: Watchdog reset sets select to 1, clears busy and pll_sel_o, and keeps the multiplier.
- R9: External-pin and software resets change no stored state, and a register write in a cycle where either is high is ignored.
- R10: While pll_sel_o is 0, mclk_en_o is high on one cycle out of every MAIN_DIV (default 2). While pll_sel_o is 1, it is constantly high.
- R11: mult_o shows the stored multiplier code: 00, 01, 10 and 11 ask the PLL for 1x, 2x, 3x and 4x the oscillator frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| wdt_rst_i | input | 1 | Watchdog reset, synchronous, active high |
| ext_rst_i | input | 1 | External-pin reset, synchronous, active high |
| sw_rst_i | input | 1 | Software reset, synchronous, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 3 | Write data: bit 2 select, bits 1:0 multiplier |
| rd_data_o | output | 4 | Read data: busy, select, multiplier |
| pll_sel_o | output | 1 | 1 = clock switch takes the PLL clock |
| mult_o | output | 2 | PLL multiplier code |
| tb_clr_o | output | 1 | One-cycle clear for the timebase timer and its overflow flag |
| mclk_en_o | output | 1 | Machine-clock enable in the main clock domain |

## Verification
The bench counts the busy window cycle by cycle. A counter that is off by one, or a switch to the PLL that comes early, shows up as a wrong length or as pll_sel_o rising while busy is still high. The bench writes the multiplier while the PLL is selected and writes 0 to a select bit that is already 0. A design with a missing lock would change mult_o, and one that re-triggered would pulse the timebase clear again. The bench aborts a wait and then waits past its natural end, which catches a design that still switches late. It also fires each reset type in PLL mode with a write in the same cycle. That exposes a multiplier cleared by the watchdog, or a select bit moved by an external or software reset.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
   // field positions of the clock select register
   localparam int MULT_W    = 2;
   localparam int SEL_POS   = 2;
   localparam int BUSY_POS  = 3;
   localparam int WDATA_W   = MULT_W + 1;
   localparam int RDATA_W   = MULT_W + 2;

   typedef logic [MULT_W-1:0] mult_t;
endpackage

// File: rtl/csc_wait_timer.sv
module csc_wait_timer #(
   parameter int WAIT_LOG2 = 13
) (
   input  logic clk_i,
   input  logic clr_i,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = WAIT_LOG2;

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '1;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0) && !start_i;

   AST_WAIT_COUNTS_DOWN: assert property (@(posedge clk_i) disable iff (clr_i)
      (busy_q && cnt_q != '0 && !start_i) |=> (busy_q || clr_i)); // R3
endmodule

// File: rtl/csc_clk_en.sv
module csc_clk_en #(
   parameter int MAIN_DIV = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic pll_sel_i,
   output logic en_o
);
   localparam int DW = (MAIN_DIV > 2) ? $clog2(MAIN_DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(MAIN_DIV - 1);

   logic [DW-1:0] div_q;

   generate
      if (MAIN_DIV < 2) begin : g_bad_div
         $error("MAIN_DIV must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)              div_q <= '0;
      else if (div_q == LAST) div_q <= '0;
      else                    div_q <= div_q + 1'b1;
   end

   assign en_o = pll_sel_i || (div_q == LAST);

   AST_DIV_EN_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (!pll_sel_i && en_o) |=> (!en_o || pll_sel_i)); // R10
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
   import clk_src_pkg::*;
#(
   parameter int WAIT_LOG2 = 13,
   parameter int MAIN_DIV  = 2
) (
   input  logic               clk_i,
   input  logic               por_i,
   input  logic               wdt_rst_i,
   input  logic               ext_rst_i,
   input  logic               sw_rst_i,
   input  logic               wr_en_i,
   input  logic [WDATA_W-1:0] wr_data_i,
   output logic [RDATA_W-1:0] rd_data_o,
   output logic               pll_sel_o,
   output logic [MULT_W-1:0]  mult_o,
   output logic               tb_clr_o
   ,
   output logic               mclk_en_o
);
   generate
      if (WAIT_LOG2 < 2 || WAIT_LOG2 > 24) begin : g_bad_wait
         $error("WAIT_LOG2 out of range 2..24");
      end
   endgenerate

   logic  sel_q;      // 1 = main clock requested
   mult_t mult_q;
   logic  pll_act_q;
   logic  tb_clr_q;
   logic  busy, done;

   // writes are dropped while an external or software reset is applied
   logic wr_ok, go_pll, go_main, tmr_clr;
   assign wr_ok   = wr_en_i && !ext_rst_i && !sw_rst_i;
   assign go_pll  = wr_ok && sel_q && !wr_data_i[SEL_POS];
   assign go_main = wr_ok && wr_data_i[SEL_POS];
   assign tmr_clr = por_i || wdt_rst_i || go_main;

   csc_wait_timer #(.WAIT_LOG2(WAIT_LOG2)) u_wait (
      .clk_i  (clk_i),
      .clr_i  (tmr_clr),
      .start_i(go_pll),
      .busy_o (busy),
      .done_o (done)
   );

   always_ff @(posedge clk_i) begin
      if (por_i) begin
         sel_q     <= 1'b1;
         mult_q    <= '0;
         pll_act_q <= 1'b0;
         tb_clr_q  <= 1'b0;
      end else if (wdt_rst_i) begin
         sel_q     <= 1'b1;
         pll_act_q <= 1'b0;
         tb_clr_q  <= 1'b0;
      end else begin
         tb_clr_q <= go_pll;
         if (done) pll_act_q <= 1'b1;
         if (wr_ok) begin
            if (sel_q) mult_q <= wr_data_i[MULT_W-1:0];
            sel_q <= wr_data_i[SEL_POS];
            if (wr_data_i[SEL_POS]) pll_act_q <= 1'b0;
         end
      end
   end

   csc_clk_en #(.MAIN_DIV(MAIN_DIV)) u_en (
      .clk_i    (clk_i),
      .rst_i    (por_i),
      .pll_sel_i(pll_act_q),
      .en_o     (mclk_en_o)
   );

   assign rd_data_o = {busy, sel_q, mult_q};
   assign pll_sel_o = pll_act_q;
   assign mult_o    = mult_q;
   assign tb_clr_o  = tb_clr_q;

   AST_PLL_NEEDS_SEL0: assert property (@(posedge clk_i) disable iff (por_i)
      pll_act_q |-> !sel_q); // R1
   AST_NO_PLL_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (por_i)
      busy |-> !pll_act_q); // R5
   AST_TBCLR_SINGLE: assert property (@(posedge clk_i) disable iff (por_i)
      tb_clr_q |=> !tb_clr_q); // R4
   AST_WAIT_WITH_CLEAR: assert property (@(posedge clk_i) disable iff (por_i)
      $rose(busy) |-> tb_clr_q); // R3
   AST_MULT_LOCKED: assert property (@(posedge clk_i) disable iff (por_i)
      !sel_q |=> $stable(mult_q)); // R7
   AST_WDT_TO_MAIN: assert property (@(posedge clk_i) disable iff (por_i)
      wdt_rst_i |=> (sel_q && !busy && !pll_act_q)); // R8
endmodule

// File: tb/sim_clk_src_ctrl.sv
module sim_clk_src_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int WAIT_CYC   = 8192;

   logic       clk = 1'b0;
   logic       por = 1'b1, wdt = 1'b0, ext = 1'b0, sw = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_data = '0;
   logic [3:0] rd;
   logic       pll_sel, tb_clr, mclk_en;
   logic [1:0] mult;

   int tests = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_src_ctrl u0 (
      .clk_i(clk), .por_i(por), .wdt_rst_i(wdt), .ext_rst_i(ext), .sw_rst_i(sw),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd), .pll_sel_o(pll_sel),
      .mult_o(mult), .tb_clr_o(tb_clr), .mclk_en_o(mclk_en)
   );

   // {write data, expected read data}, all in main-clock mode
   localparam logic [6:0] VEC [4] = '{
      {3'b101, 4'b0101}, {3'b111, 4'b0111}, {3'b100, 4'b0100}, {3'b110, 4'b0110}
   };

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_en(output int n);
      n = 0;
      for (int i = 0; i < 8; i++) begin
         if (mclk_en) n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n, bad;
      repeat (3) @(negedge clk);
      por = 1'b0;
      chk("R2 reset read", rd, 4'b0100);
      chk("R2 reset pll_sel", pll_sel, 0);
      chk("R2 reset tb_clr", tb_clr, 0);
      count_en(n);
      chk("R10 main enable rate", n, 4);

      for (int i = 0; i < 4; i++) begin
         wr(VEC[i][6:4]);
         chk("R7 R1 table read", rd, VEC[i][3:0]);
         chk("R11 mult_o", mult, VEC[i][1:0]);
      end

      // select PLL; multiplier 10 kept
      wr(3'b010);
      chk("R4 clear pulse", tb_clr, 1);
      chk("R3 busy on", rd[3], 1);
      chk("R5 main during wait", pll_sel, 0);
      n = 0; bad = 0;
      while (rd[3] && n < 20000) begin
         n++;
         if (pll_sel || (n > 1 && tb_clr)) bad++;
         @(negedge clk);
      end
      chk("R3 wait length", n, WAIT_CYC);
      chk("R4 R5 no early switch or repeat clear", bad, 0);
      chk("R5 pll after wait", pll_sel, 1);
      chk("R1 read in pll mode", rd, 4'b0010);
      count_en(n);
      chk("R10 pll enable constant", n, 8);

      wr(3'b011);
      chk("R7 mult locked", rd, 4'b0010);
      chk("R11 mult_o locked", mult, 2'b10);
      chk("R4 no pulse when already pll", tb_clr, 0);

      ext = 1'b1; wr(3'b111); ext = 1'b0;
      chk("R9 ext reset keeps state", rd, 4'b0010);
      chk("R9 ext reset keeps pll", pll_sel, 1);
      sw = 1'b1; wr(3'b111); sw = 1'b0;
      chk("R9 sw reset keeps state", rd, 4'b0010);
      chk("R9 sw reset keeps pll", pll_sel, 1);

      wdt = 1'b1; @(negedge clk); wdt = 1'b0;
      chk("R8 wdt read", rd, 4'b0110);
      chk("R8 wdt pll_sel", pll_sel, 0);

      wr(3'b000);
      chk("R7 mult taken with select write", mult, 2'b00);
      repeat (100) @(negedge clk);
      chk("R3 still busy", rd[3], 1);
      wr(3'b101);
      chk("R6 abort read", rd, 4'b0100);
      bad = 0;
      for (int i = 0; i < WAIT_CYC + 200; i++) begin
         if (pll_sel || rd[3]) bad++;
         @(negedge clk);
      end
      chk("R6 no late switch", bad, 0);

      wr(3'b111);
      por = 1'b1; @(negedge clk); por = 1'b0;
      chk("R2 por clears mult", rd, 4'b0100);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule